// File: doc/BRIEF.md
# One-Shot Event Timer with Interrupt

This block is a register-mapped down-counting event timer. Each timer clock stands for one tick of an effective 100 MHz time base, so one count is 10 ns. Software writes a 32-bit divisor and then steers the counter with commands written to a control register. A load copies the divisor into the counter and leaves it held. A run lets it count down by one per clock. A hold freezes it. When the counter reaches zero, a pending flag is raised. That flag appears on the interrupt output when its enable bit is set, and it is cleared by writing 1 to the acknowledge register. While the counter runs, software can read back the current count; the time elapsed since the run command is (divisor − count) ticks.

Next to the event counter, the block keeps a free-running up-counter. It advances every clock, cannot be written and wraps at its width, which makes it usable as a timestamp.

The command sequencer is a three-state machine. In HELD the counter keeps its value. In COUNTING it decrements once per clock. In EXPIRED it sits at zero.
- The transition `start` goes from HELD to COUNTING. It is taken on a run command when the count is non-zero.
- The transition `pause` goes from COUNTING to HELD. It is taken on a hold command.
- The transition `fire` goes from COUNTING to EXPIRED. It is taken on the clock where the count steps from 1 to 0.
- The transition `reload` goes from any state to HELD on a load command, and copies the divisor into the counter.

Register map (3-bit word address):

| Address | Access | Content |
|---|---|---|
| 0 | read/write | divisor |
| 1 | write-only | command in bits [1:0]; reads as 0 |
| 2 | read-only | current count |
| 3 | read-only | timestamp |
| 4 | read/write | interrupt enable in bit 0 |
| 5 | write-only | acknowledge in bit 0; reads as 0 |
| 6 | read-only | raw pending flag in bit 0 |
| 7 | read-only | masked pending in bit 0 |

Top module: `evt_timer`

## Requirements
- R1: After reset, the divisor, count, timestamp, enable, pending flag, masked status and `irq` all read 0.
- R2: Writing command code 1 (load) to bits [1:0] at address 1 copies the divisor from address 0 into the counter. The counter then stays at that value until a run command is written.
- R3: After command code 2 (run), the count read back is unchanged on the first clock. It then drops by one on each following clock. With count D at the run, the pending flag (address 6, bit 0) becomes 1 exactly D clocks after the run write.
- R4: Command code 0 (hold) freezes the count, and the unused code 3 acts the same as hold. A later run command resumes counting from the frozen value.
- R5: Once the count reaches 0, it stays at 0 and a run command has no effect until a load is written. Neither hold nor run clears the pending flag.
- R6: Address 4 bit 0 enables the interrupt. Address 7 bit 0 and the `irq` output both equal pending AND enable. Address 6 bit 0 shows the pending flag whatever the enable is.
- R7: Writing 1 to bit 0 of address 5 clears the pending flag. Writing 0 there leaves it unchanged.
- R8: If an acknowledge write lands on the same clock as an expiry, the pending flag ends up set.
- R9: The timestamp at address 3 grows by one every clock and wraps to 0 at its width.
- R10: A load written while the counter runs replaces the count with the divisor and holds it, with no expiry. A divisor write alone does not disturb a running count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock, one tick per count |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr`, combinational |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench aims at the exact cycle of expiry. A counter that decrements on the same clock as the run write, or that flags at count 1, would raise the pending flag one clock early. The bench writes an acknowledge on the very clock of an expiry, so a design that lets the acknowledge win would drop the interrupt. It issues run commands after expiry, and a design that wraps the count to all ones would start counting again. It also reloads mid-count, uses the spare command code, writes an acknowledge of 0, and lets a narrowed timestamp wrap, so that a design that treats code 3 as run, clears the flag on any acknowledge write, or saturates the timestamp shows a wrong value.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_RUN  = 2'd2,
        OP_RSVD = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        S_HELD  = 2'd0,
        S_COUNT = 2'd1,
        S_DONE  = 2'd2
    } tstate_e;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADR_DIV   = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_CTRL  = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_CNT   = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_TIME  = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_MASK  = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_ACK   = 3'd5;
    localparam logic [ADDR_W-1:0] ADR_RAW   = 3'd6;
    localparam logic [ADDR_W-1:0] ADR_MSKD  = 3'd7;

endpackage

// File: rtl/evt_ctrl_fsm.sv
module evt_ctrl_fsm
    import evt_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  op_e              op,
    input  logic [CNT_W-1:0] divisor,
    output logic [CNT_W-1:0] count,
    output logic             expire,
    output logic             running
);

    tstate_e          st_q, st_d;
    logic [CNT_W-1:0] cnt_d;
    logic             is_hold;

    assign is_hold = op_valid && (op == OP_HOLD || op == OP_RSVD);

    // state and counter registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= S_HELD;
            count <= '0;
        end else begin
            st_q  <= st_d;
            count <= cnt_d;
        end
    end

    // next state and outputs
    always_comb begin
        st_d   = st_q;
        cnt_d  = count;
        expire = 1'b0;
        if (op_valid && op == OP_LOAD) begin
            st_d  = S_HELD;
            cnt_d = divisor;
        end else begin
            unique case (st_q)
                S_HELD: begin
                    if (op_valid && op == OP_RUN && count != '0)
                        st_d = S_COUNT;
                end
                S_COUNT: begin
                    if (is_hold) begin
                        st_d = S_HELD;
                    end else begin
                        cnt_d = count - CNT_W'(1);
                        if (count == CNT_W'(1)) begin
                            expire = 1'b1;
                            st_d   = S_DONE;
                        end
                    end
                end
                S_DONE: begin
                    st_d = S_DONE;
                end
                default: begin
                    st_d = S_HELD;
                end
            endcase
        end
    end

    assign running = (st_q == S_COUNT);

endmodule

// File: rtl/evt_irq.sv
module evt_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic ack,
    input  logic mask_wr,
    input  logic mask_wdata,
    output logic pending,
    output logic mask,
    output logic irq
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (expire) begin
            pending <= 1'b1;
        end else if (ack) begin
            pending <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask <= 1'b0;
        end else if (mask_wr) begin
            mask <= mask_wdata;
        end
    end

    assign irq = pending & mask;

endmodule

// File: rtl/evt_timestamp.sv
module evt_timestamp #(
    parameter int TIME_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [TIME_W-1:0] stamp
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stamp <= '0;
        end else begin
            stamp <= stamp + TIME_W'(1);
        end
    end

endmodule

// File: rtl/evt_timer.sv
module evt_timer
    import evt_timer_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32,
    parameter int TIME_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);

    logic [CNT_W-1:0]  div_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [TIME_W-1:0] time_q;
    logic              expire;
    logic              running;
    logic              pending_q;
    logic              mask_q;
    logic              ctrl_wr;
    logic              ack_wr;
    logic              mask_wr;

    assign ctrl_wr = wr_en && (addr == ADR_CTRL);
    assign ack_wr  = wr_en && (addr == ADR_ACK) && wdata[0];
    assign mask_wr = wr_en && (addr == ADR_MASK);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (wr_en && addr == ADR_DIV) begin
            div_q <= wdata[CNT_W-1:0];
        end
    end

    evt_ctrl_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (ctrl_wr),
        .op       (op_e'(wdata[1:0])),
        .divisor  (div_q),
        .count    (cnt_q),
        .expire   (expire),
        .running  (running)
    );

    evt_irq u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .expire     (expire),
        .ack        (ack_wr),
        .mask_wr    (mask_wr),
        .mask_wdata (wdata[0]),
        .pending    (pending_q),
        .mask       (mask_q),
        .irq        (irq)
    );

    evt_timestamp #(.TIME_W(TIME_W)) u_ts (
        .clk   (clk),
        .rst_n (rst_n),
        .stamp (time_q)
    );

    always_comb begin
        rdata = '0;
        unique case (addr)
            ADR_DIV:  rdata = DATA_W'(div_q);
            ADR_CNT:  rdata = DATA_W'(cnt_q);
            ADR_TIME: rdata = DATA_W'(time_q);
            ADR_MASK: rdata = DATA_W'(mask_q);
            ADR_RAW:  rdata = DATA_W'(pending_q);
            ADR_MSKD: rdata = DATA_W'(irq);
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk
    import evt_timer_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int TIME_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [2:0]        addr,
    input logic [1:0]        wlow,
    input logic [CNT_W-1:0]  count,
    input logic              running,
    input logic              pending,
    input logic              mask,
    input logic              irq,
    input logic [TIME_W-1:0] stamp
);

    logic ctrl_w, load_w, ack_w;
    assign ctrl_w = wr_en && addr == ADR_CTRL;
    assign load_w = ctrl_w && wlow == 2'd1;
    assign ack_w  = wr_en && addr == ADR_ACK && wlow[0];

    // R5
    count_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && !load_w) |=> count == '0);

    // R3
    count_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !ctrl_w) |=> count == $past(count) - CNT_W'(1));

    // R7
    pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !ack_w) |=> pending);

    // R8
    exp_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && count == CNT_W'(1) && !ctrl_w) |=> pending);

    // R6
    irq_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && mask) |-> irq);

    // R6
    irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mask |-> !irq);

    // R9
    time_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> stamp == $past(stamp) + TIME_W'(1));

endmodule

bind evt_timer evt_timer_chk #(.CNT_W(CNT_W), .TIME_W(TIME_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wlow    (wdata[1:0]),
    .count   (cnt_q),
    .running (running),
    .pending (pending_q),
    .mask    (mask_q),
    .irq     (irq),
    .stamp   (time_q)
);

// File: tb/tb_evt_timer.sv
module tb_evt_timer;

    localparam int DW = 32;
    localparam int TW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          irq;

    int checks = 0;
    int errors = 0;

    evt_timer #(.DATA_W(DW), .CNT_W(32), .TIME_W(TW)) dut (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .irq   (irq)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    // called at a negedge; returns at the next negedge
    task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [DW-1:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [DW-1:0] v;
        for (int a = 0; a < 8; a++) begin
            rd(a[2:0], v);
            if (a == 3) chk("R1 timestamp", v, 1);
            else chk("R1 reset value", v, 0);
        end
        chk("R1 irq", {31'd0, irq}, 0);
    endtask

    task automatic t_load_run();
        logic [DW-1:0] v;
        wr(3'd0, 10);
        wr(3'd1, 1);
        rd(3'd2, v); chk("R2 load copies divisor", v, 10);
        waitn(3);
        rd(3'd2, v); chk("R2 held after load", v, 10);
        wr(3'd1, 2);
        rd(3'd2, v); chk("R3 first clock unchanged", v, 10);
        waitn(4);
        rd(3'd2, v); chk("R3 count after 4", v, 6);
        waitn(5);
        rd(3'd2, v); chk("R3 count at 1", v, 1);
        rd(3'd6, v); chk("R3 not yet pending", v, 0);
        waitn(1);
        rd(3'd2, v); chk("R3 count at 0", v, 0);
        rd(3'd6, v); chk("R3 pending at D", v, 1);
    endtask

    task automatic t_expire_stop();
        logic [DW-1:0] v;
        wr(3'd1, 2);
        waitn(3);
        rd(3'd2, v); chk("R5 run after expiry ignored", v, 0);
        wr(3'd1, 0);
        rd(3'd6, v); chk("R5 pending kept", v, 1);
    endtask

    task automatic t_mask();
        logic [DW-1:0] v;
        rd(3'd7, v); chk("R6 masked off", v, 0);
        chk("R6 irq off", {31'd0, irq}, 0);
        wr(3'd4, 1);
        rd(3'd7, v); chk("R6 masked on", v, 1);
        chk("R6 irq on", {31'd0, irq}, 1);
        rd(3'd6, v); chk("R6 raw", v, 1);
    endtask

    task automatic t_ack();
        logic [DW-1:0] v;
        wr(3'd5, 0);
        rd(3'd6, v); chk("R7 ack of 0 no effect", v, 1);
        wr(3'd5, 1);
        rd(3'd6, v); chk("R7 ack clears", v, 0);
        chk("R7 irq cleared", {31'd0, irq}, 0);
    endtask

    task automatic t_hold();
        logic [DW-1:0] v;
        wr(3'd0, 20);
        wr(3'd1, 1);
        wr(3'd1, 2);
        waitn(5);
        rd(3'd2, v); chk("R3 running", v, 15);
        wr(3'd1, 0);
        rd(3'd2, v); chk("R4 hold freezes", v, 15);
        waitn(4);
        rd(3'd2, v); chk("R4 still frozen", v, 15);
        wr(3'd1, 2);
        waitn(2);
        rd(3'd2, v); chk("R4 resume", v, 13);
        wr(3'd1, 3);
        waitn(3);
        rd(3'd2, v); chk("R4 code 3 holds", v, 13);
        rd(3'd6, v); chk("R4 no pending", v, 0);
    endtask

    task automatic t_collision();
        logic [DW-1:0] v;
        wr(3'd0, 3);
        wr(3'd1, 1);
        wr(3'd1, 2);
        waitn(2);
        wr(3'd5, 1);
        rd(3'd2, v); chk("R8 expired", v, 0);
        rd(3'd6, v); chk("R8 expiry wins", v, 1);
        wr(3'd5, 1);
    endtask

    task automatic t_reload();
        logic [DW-1:0] v;
        wr(3'd0, 50);
        wr(3'd1, 1);
        wr(3'd1, 2);
        waitn(5);
        wr(3'd0, 7);
        rd(3'd2, v); chk("R10 divisor write leaves count", v, 44);
        wr(3'd1, 1);
        rd(3'd2, v); chk("R10 reload", v, 7);
        waitn(10);
        rd(3'd2, v); chk("R10 held after reload", v, 7);
        rd(3'd6, v); chk("R10 no expiry", v, 0);
    endtask

    task automatic t_time();
        logic [DW-1:0] a, b;
        rd(3'd3, a);
        waitn(7);
        rd(3'd3, b);
        chk("R9 increments", b, (a + 7) & 32'hFF);
        for (int i = 0; i < 300; i++) begin
            rd(3'd3, a);
            if (a == 32'hFF) break;
            @(negedge clk);
        end
        chk("R9 reaches top", a, 32'hFF);
        waitn(1);
        rd(3'd3, b); chk("R9 wraps", b, 0);
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        waitn(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load_run();
        t_expire_stop();
        t_mask();
        t_ack();
        t_hold();
        t_collision();
        t_reload();
        t_time();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule